// File: doc/BRIEF.md
# Aliased Multi-Width Register File

This block holds a bank of general-purpose registers. By default there are eight of them, each 32 bits wide. The same storage can be reached through three overlapping views. The long view sees each register whole. The word view sees sixteen 16-bit halves: the lower half and the extended upper half of every register. The byte view sees sixteen 8-bit fields carved out of the lower halves. A datapath uses the block as its operand store. Two combinational read ports feed the operands, and one write port takes results back at the rising clock edge.

Each port carries a 4-bit register index and a 2-bit size code. The write port merges narrow data into the selected bytes only. The read ports return narrow fields right-aligned and zero-extended to 32 bits. A read that names bytes being written in the same cycle sees the incoming data for exactly those bytes. All other bytes of the read come from storage.

Top module: `mwrf_regfile`

## Requirements
- R1: While reset (rst_n low, asynchronous) is active, every register clears to zero, and all views then read zero.
- R2: Size code 2 selects long access. Index bits [2:0] pick the whole 32-bit register, and index bit 3 has no effect.
- R3: Size code 1 selects word access. Index 0-7 maps to bits [15:0] of register idx, and index 8-15 maps to bits [31:16] of register idx-8.
- R4: Size code 0 selects byte access. Index 0-7 maps to bits [15:8] of register idx, and index 8-15 maps to bits [7:0] of register idx-8.
- R5: A byte or word write takes its data from the low 8 or 16 bits of wr_data and changes only the selected bytes. Every other byte of that register keeps its value.
- R6: Byte and word reads return the selected field in the low bits of the read data, with all upper bits zero.
- R7: Read data follows the read inputs combinationally, in the same cycle. A write becomes visible in storage after the rising edge on which wr_en is high.
- R8: When wr_en is high and a read addresses the same register, each byte that both accesses touch returns the new write data. Bytes that do not overlap return the stored value.
- R9: The two read ports are independent. With wr_en low, storage stays unchanged whatever the other write inputs carry.
- R10: Size code 3 behaves exactly like size code 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes commit on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 4 | Write register index, interpreted according to wr_size |
| wr_size | input | 2 | Write size: 0 byte, 1 word, 2 or 3 long |
| wr_data | input | 32 | Write data, right-aligned for narrow sizes |
| ra_idx | input | 4 | Read port A index |
| ra_size | input | 2 | Read port A size |
| ra_data | output | 32 | Read port A data, zero-extended |
| rb_idx | input | 4 | Read port B index |
| rb_size | input | 2 | Read port B size |
| rb_data | output | 32 | Read port B data, zero-extended |

## Verification
Read results are combinational. They are due in the same cycle as the index and size that select them, so the bench changes read inputs on the falling edge and samples one nanosecond later, well clear of the next rising edge. A write counts one register stage. Its effect is checked only after the rising edge that captures it. Forwarded results are due in the cycle the write is presented, so they are sampled between that falling edge and the capturing rising edge, before storage has changed.

// File: rtl/mwrf_pkg.sv
package mwrf_pkg;
   // Access size codes shared by all ports
   localparam logic [1:0] SZ_BYTE = 2'd0;
   localparam logic [1:0] SZ_WORD = 2'd1;
   localparam logic [1:0] SZ_LONG = 2'd2;
   // Byte lanes in one register: [3] ext high, [2] ext low, [1] low-half high, [0] low-half low
   localparam int LANES = 4;
endpackage

// File: rtl/mwrf_lane_decode.sv
module mwrf_lane_decode
   import mwrf_pkg::*;
#(
   parameter int NREG = 8
) (
   input  logic [$clog2(NREG):0]   idx,
   input  logic [1:0]              size,
   output logic [$clog2(NREG)-1:0] rsel,
   output logic [LANES-1:0]        be,
   output logic [1:0]              lane
);
   localparam int RSEL_W = $clog2(NREG);

   logic upper;

   always_comb begin
      rsel  = idx[RSEL_W-1:0];
      upper = idx[RSEL_W];
      unique case (size)
         SZ_BYTE: begin
            be   = upper ? 4'b0001 : 4'b0010;
            lane = upper ? 2'd0 : 2'd1;
         end
         SZ_WORD: begin
            be   = upper ? 4'b1100 : 4'b0011;
            lane = upper ? 2'd2 : 2'd0;
         end
         default: begin
            be   = 4'b1111;
            lane = 2'd0;
         end
      endcase
   end
endmodule

// File: rtl/mwrf_wr_align.sv
module mwrf_wr_align
   import mwrf_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic [1:0]              size,
   input  logic [LANES*BYTE_W-1:0] din,
   output logic [LANES*BYTE_W-1:0] dout
);
   // Replicate narrow data into every lane; the byte enables pick the lanes
   always_comb begin
      unique case (size)
         SZ_BYTE: dout = {LANES{din[BYTE_W-1:0]}};
         SZ_WORD: dout = {(LANES/2){din[2*BYTE_W-1:0]}};
         default: dout = din;
      endcase
   end
endmodule

// File: rtl/mwrf_rd_port.sv
module mwrf_rd_port
   import mwrf_pkg::*;
#(
   parameter int NREG   = 8,
   parameter int BYTE_W = 8
) (
   input  logic [LANES*BYTE_W-1:0] rows [NREG],
   input  logic [$clog2(NREG):0]   idx,
   input  logic [1:0]              size,
   input  logic                    wr_en,
   input  logic [$clog2(NREG)-1:0] wr_rsel,
   input  logic [LANES-1:0]        wr_be,
   input  logic [LANES*BYTE_W-1:0] wr_word,
   output logic [LANES*BYTE_W-1:0] dout
);
   localparam int RSEL_W = $clog2(NREG);
   localparam int DATA_W = LANES * BYTE_W;

   logic [RSEL_W-1:0] rsel;
   logic [LANES-1:0]  be_unused;
   logic [1:0]        lane;
   logic [DATA_W-1:0] stored;
   logic [DATA_W-1:0] merged;
   logic              hit;

   mwrf_lane_decode #(.NREG(NREG)) u_dec (
      .idx (idx),
      .size(size),
      .rsel(rsel),
      .be  (be_unused),
      .lane(lane)
   );

   assign stored = rows[rsel];
   assign hit    = wr_en && (wr_rsel == rsel);

   // Per-lane forwarding: only bytes the write touches take the new data
   for (genvar k = 0; k < LANES; k++) begin : g_fwd
      assign merged[k*BYTE_W +: BYTE_W] = (hit && wr_be[k]) ?
                                          wr_word[k*BYTE_W +: BYTE_W] :
                                          stored[k*BYTE_W +: BYTE_W];
   end

   always_comb begin
      dout = '0;
      unique case (size)
         SZ_BYTE: dout[BYTE_W-1:0]   = merged[int'(lane)*BYTE_W +: BYTE_W];
         SZ_WORD: dout[2*BYTE_W-1:0] = merged[int'(lane)*BYTE_W +: 2*BYTE_W];
         default: dout = merged;
      endcase
   end
endmodule

// File: rtl/mwrf_regfile.sv
module mwrf_regfile
   import mwrf_pkg::*;
#(
   parameter int NREG   = 8,
   parameter int BYTE_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [$clog2(NREG):0]   wr_idx,
   input  logic [1:0]              wr_size,
   input  logic [4*BYTE_W-1:0]     wr_data,
   input  logic [$clog2(NREG):0]   ra_idx,
   input  logic [1:0]              ra_size,
   output logic [4*BYTE_W-1:0]     ra_data,
   input  logic [$clog2(NREG):0]   rb_idx,
   input  logic [1:0]              rb_size,
   output logic [4*BYTE_W-1:0]     rb_data
);
   localparam int RSEL_W = $clog2(NREG);
   localparam int DATA_W = LANES * BYTE_W;

   if (NREG < 2 || (NREG & (NREG - 1)) != 0) begin : g_chk_nreg
      $error("mwrf_regfile: NREG must be a power of two, at least 2");
   end
   if (BYTE_W < 1) begin : g_chk_byte
      $error("mwrf_regfile: BYTE_W must be positive");
   end
   if (DATA_W != 4 * BYTE_W) begin : g_chk_lanes
      $error("mwrf_regfile: lane count must be four");
   end

   logic [DATA_W-1:0] rows [NREG];
   logic [RSEL_W-1:0] w_rsel;
   logic [LANES-1:0]  w_be;
   logic [1:0]        w_lane_unused;
   logic [DATA_W-1:0] w_word;

   mwrf_lane_decode #(.NREG(NREG)) u_wdec (
      .idx (wr_idx),
      .size(wr_size),
      .rsel(w_rsel),
      .be  (w_be),
      .lane(w_lane_unused)
   );

   mwrf_wr_align #(.BYTE_W(BYTE_W)) u_walign (
      .size(wr_size),
      .din (wr_data),
      .dout(w_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int r = 0; r < NREG; r++) rows[r] <= '0;
      end else if (wr_en) begin
         for (int k = 0; k < LANES; k++) begin
            if (w_be[k]) rows[w_rsel][k*BYTE_W +: BYTE_W] <= w_word[k*BYTE_W +: BYTE_W];
         end
      end
   end

   mwrf_rd_port #(.NREG(NREG), .BYTE_W(BYTE_W)) u_rda (
      .rows   (rows),
      .idx    (ra_idx),
      .size   (ra_size),
      .wr_en  (wr_en),
      .wr_rsel(w_rsel),
      .wr_be  (w_be),
      .wr_word(w_word),
      .dout   (ra_data)
   );

   mwrf_rd_port #(.NREG(NREG), .BYTE_W(BYTE_W)) u_rdb (
      .rows   (rows),
      .idx    (rb_idx),
      .size   (rb_size),
      .wr_en  (wr_en),
      .wr_rsel(w_rsel),
      .wr_be  (w_be),
      .wr_word(w_word),
      .dout   (rb_data)
   );

   // Storage checks, one set per register
   for (genvar r = 0; r < NREG; r++) begin : g_ast
      AST_RESET_CLEAR: assert property (@(posedge clk)
         !rst_n |=> rows[r] == '0); // R1
      AST_LONG_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
         wr_en && wr_size[1] && wr_idx[RSEL_W-1:0] == r |=> rows[r] == $past(wr_data)); // R2
      AST_BYTE_KEEPS_EXT: assert property (@(posedge clk) disable iff (!rst_n)
         wr_en && wr_size == SZ_BYTE && wr_idx[RSEL_W-1:0] == r
         |=> $stable(rows[r][DATA_W-1:2*BYTE_W])); // R5
      AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
         !wr_en |=> $stable(rows[r])); // R9
   end

   // Port-level checks
   AST_ZEXT_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      ra_size == SZ_BYTE |-> ra_data[DATA_W-1:BYTE_W] == '0); // R6
   AST_ZEXT_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      rb_size == SZ_WORD |-> rb_data[DATA_W-1:2*BYTE_W] == '0); // R6
   AST_FWD_LONG: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && wr_size[1] && ra_size[1] && ra_idx[RSEL_W-1:0] == wr_idx[RSEL_W-1:0]
      |-> ra_data == wr_data); // R8
endmodule

// File: tb/mwrf_regfile_test.sv
module mwrf_regfile_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_idx = '0;
   logic [1:0]  wr_size = '0;
   logic [31:0] wr_data = '0;
   logic [3:0]  ra_idx = '0;
   logic [1:0]  ra_size = 2'd2;
   logic [31:0] ra_data;
   logic [3:0]  rb_idx = '0;
   logic [1:0]  rb_size = 2'd2;
   logic [31:0] rb_data;

   int n_chk = 0;
   int n_fail = 0;
   logic [31:0] m [8];

   always #4 clk = ~clk;  // 125 MHz

   mwrf_regfile uut (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_size(wr_size), .wr_data(wr_data),
      .ra_idx(ra_idx), .ra_size(ra_size), .ra_data(ra_data),
      .rb_idx(rb_idx), .rb_size(rb_size), .rb_data(rb_data)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Model from the requirements: mapping per R2/R3/R4, merge per R5
   task automatic mdl_write(input logic [3:0] idx, input logic [1:0] sz, input logic [31:0] d);
      int r = int'(idx[2:0]);
      case (sz)
         2'd0: if (idx[3]) m[r][7:0] = d[7:0]; else m[r][15:8] = d[7:0];
         2'd1: if (idx[3]) m[r][31:16] = d[15:0]; else m[r][15:0] = d[15:0];
         default: m[r] = d;
      endcase
   endtask

   function automatic logic [31:0] mdl_read(input logic [3:0] idx, input logic [1:0] sz);
      int r = int'(idx[2:0]);
      case (sz)
         2'd0: return idx[3] ? {24'h0, m[r][7:0]} : {24'h0, m[r][15:8]};
         2'd1: return idx[3] ? {16'h0, m[r][31:16]} : {16'h0, m[r][15:0]};
         default: return m[r];
      endcase
   endfunction

   // Expected forwarded read (R8): apply the write to a copy, read, restore
   task automatic mdl_fwd(input logic [3:0] widx, input logic [1:0] wsz, input logic [31:0] wd,
                          input logic [3:0] ridx, input logic [1:0] rsz, output logic [31:0] res);
      logic [31:0] saved = m[widx[2:0]];
      mdl_write(widx, wsz, wd);
      res = mdl_read(ridx, rsz);
      m[widx[2:0]] = saved;
   endtask

   task automatic do_write(input logic [3:0] idx, input logic [1:0] sz, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_idx = idx; wr_size = sz; wr_data = d;
      @(posedge clk);
      #1;
      wr_en = 1'b0;
      mdl_write(idx, sz, d);
   endtask

   task automatic read_a(input string req, input logic [3:0] idx, input logic [1:0] sz);
      @(negedge clk);
      ra_idx = idx; ra_size = sz;
      #1;
      check(req, ra_data, mdl_read(idx, sz));
   endtask

   task automatic read_b(input string req, input logic [3:0] idx, input logic [1:0] sz);
      @(negedge clk);
      rb_idx = idx; rb_size = sz;
      #1;
      check(req, rb_data, mdl_read(idx, sz));
   endtask

   task automatic t_reset();
      for (int r = 0; r < 8; r++) m[r] = '0;
      for (int r = 0; r < 8; r++) read_a("R1 reset long", 4'(r), 2'd2);
      read_b("R1 reset byte", 4'd9, 2'd0);
      read_b("R1 reset word", 4'd14, 2'd1);
   endtask

   task automatic t_long();
      for (int r = 0; r < 8; r++)
         do_write({r[0], 3'(r)}, 2'd2, 32'hA5000000 + 32'(r) * 32'h01111111);
      for (int r = 0; r < 8; r++) read_a("R2 long readback", {~r[0], 3'(r)}, 2'd2);
      read_b("R7 long visible after edge", 4'd3, 2'd2);
   endtask

   task automatic t_word();
      do_write(4'd2, 2'd1, 32'hFFFF1234);     // low half of reg 2
      do_write(4'd10, 2'd1, 32'hEEEEBEEF);    // ext half of reg 2
      read_a("R3 word low", 4'd2, 2'd1);
      read_a("R3 word ext", 4'd10, 2'd1);
      read_b("R3 word placement long", 4'd2, 2'd2);
      read_b("R6 word zero-extend", 4'd10, 2'd1);
      check("R3 word exact", rb_data, 32'h0000BEEF);
   endtask

   task automatic t_byte();
      do_write(4'd5, 2'd2, 32'h11223344);
      do_write(4'd5, 2'd0, 32'hFFFFFFAB);     // high byte of low half
      read_a("R5 byte hi keeps others", 4'd5, 2'd2);
      check("R5 byte hi exact", ra_data, 32'h1122AB44);
      do_write(4'd13, 2'd0, 32'h000000CD);    // low byte of reg 5
      read_a("R4 byte lo long", 4'd5, 2'd2);
      read_b("R4 byte lo view", 4'd13, 2'd0);
      read_b("R4 byte hi view", 4'd5, 2'd0);
      read_a("R6 byte zero-extend", 4'd13, 2'd0);
      check("R6 byte exact", ra_data, 32'h000000CD);
      do_write(4'd13, 2'd1, 32'h0000C0DE);    // ext half of reg 5
      read_a("R5 word ext keeps low", 4'd5, 2'd2);
   endtask

   task automatic t_fwd();
      logic [31:0] e;
      // Long write, word read of the ext half of the same register
      @(negedge clk);
      wr_en = 1'b1; wr_idx = 4'd6; wr_size = 2'd2; wr_data = 32'hCAFEF00D;
      ra_idx = 4'd14; ra_size = 2'd1;
      rb_idx = 4'd6;  rb_size = 2'd2;
      #1;
      mdl_fwd(4'd6, 2'd2, 32'hCAFEF00D, 4'd14, 2'd1, e);
      check("R8 fwd long->word", ra_data, e);
      mdl_fwd(4'd6, 2'd2, 32'hCAFEF00D, 4'd6, 2'd2, e);
      check("R8 fwd long->long", rb_data, e);
      @(posedge clk); #1; wr_en = 1'b0;
      mdl_write(4'd6, 2'd2, 32'hCAFEF00D);
      // Byte write, long read: only one byte forwarded
      @(negedge clk);
      wr_en = 1'b1; wr_idx = 4'd14; wr_size = 2'd0; wr_data = 32'h00000077;
      ra_idx = 4'd6; ra_size = 2'd2;
      rb_idx = 4'd6; rb_size = 2'd0;          // non-overlapping byte
      #1;
      mdl_fwd(4'd14, 2'd0, 32'h77, 4'd6, 2'd2, e);
      check("R8 partial fwd long", ra_data, e);
      check("R8 partial fwd exact", ra_data, 32'hCAFEF077);
      check("R8 no overlap byte", rb_data, 32'h000000F0);
      @(posedge clk); #1; wr_en = 1'b0;
      mdl_write(4'd14, 2'd0, 32'h77);
      // Write to another register: no forwarding, and R7 storage old before edge
      @(negedge clk);
      wr_en = 1'b1; wr_idx = 4'd1; wr_size = 2'd2; wr_data = 32'h0BADBEEF;
      ra_idx = 4'd6; ra_size = 2'd2;
      #1;
      check("R8 other reg unaffected", ra_data, m[6]);
      @(posedge clk); #1; wr_en = 1'b0;
      mdl_write(4'd1, 2'd2, 32'h0BADBEEF);
      read_a("R7 committed after edge", 4'd1, 2'd2);
   endtask

   task automatic t_idle();
      @(negedge clk);
      wr_en = 1'b0; wr_idx = 4'd0; wr_size = 2'd2; wr_data = 32'hDEADDEAD;
      @(posedge clk); #1;
      read_a("R9 idle no write", 4'd0, 2'd2);
      @(negedge clk);
      ra_idx = 4'd2; ra_size = 2'd2; rb_idx = 4'd13; rb_size = 2'd1;
      #1;
      check("R9 port A independent", ra_data, mdl_read(4'd2, 2'd2));
      check("R9 port B independent", rb_data, mdl_read(4'd13, 2'd1));
   endtask

   task automatic t_size3();
      do_write(4'd15, 2'd3, 32'h76543210);
      read_a("R10 size3 write as long", 4'd7, 2'd2);
      read_b("R10 size3 read as long", 4'd15, 2'd3);
      check("R10 size3 exact", rb_data, 32'h76543210);
   endtask

   initial begin
      #(8 * 200000);
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_long();
      t_word();
      t_byte();
      t_fwd();
      t_idle();
      t_size3();
      repeat (2) @(posedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule